// File: doc/BRIEF.md
# Single-Fault Gate Diagnosis Unit

This block diagnoses a five-gate one-bit full adder built from two XOR gates, two AND gates and one OR gate. It takes the three input bits that were applied to an adder instance and the sum and carry bits seen at that instance's outputs. It then reports which single gate, if faulty, could alone account for what was seen. The gates are called x1 (XOR of x and y, giving the middle node o), x2 (XOR of o and z, giving the sum), a1 (AND of z and o), a2 (AND of x and y) and o1 (OR of the two AND outputs, giving the carry).

The diagnosis is model based and assumes that at most one gate is broken. A broken gate may drive any value. For each gate and for each of the two values it could be stuck at, the block evaluates the adder with that one output overridden and every other gate healthy. A gate becomes a suspect when at least one of its two overrides reproduces both observed outputs. If the observation agrees with a healthy adder, the block reports no fault and clears the mask. The mask is also summarised by flags: one suspect only, or no single-gate explanation.

A request is a one-cycle strobe that carries the five observation bits. The result is registered and comes out with a valid pulse on the next clock. Between requests the result registers keep their value.

Top module: `fa_single_fault_diag`

## Requirements
- R1: `res_valid` is high in the cycle after every cycle in which `req_valid` was high and low otherwise; it is low after reset, and after reset all result outputs are zero.
- R2: When `obs_sum == x^y^z` and `obs_carry` equals the majority of x, y and z, the next result has `healthy` = 1, `suspects` = 0, `sole` = 0 and `unexplained` = 0.
- R3: `suspects` bit order is {o1, a2, a1, x2, x1}, with x1 in bit 0. On a mismatching observation, a bit is set exactly when overriding that gate's output to 0 or to 1, with all other gates healthy, gives both observed outputs.
- R4: When the observed sum is wrong, bits 4:2 (o1, a2, a1) of `suspects` are 0.
- R5: When the observed carry is wrong, bit 1 (x2) of `suspects` is 0.
- R6: `sole` is 1 exactly when one bit of `suspects` is set.
- R7: `unexplained` is 1 exactly when the observation mismatches the healthy adder and `suspects` is 0; at most one of `healthy`, `sole` and `unexplained` is high.
- R8: With x=1, y=0, z=1, observed sum 1 and carry 0, the result is `suspects` = 5'b00001 (x1) with `sole` = 1.
- R9: In a cycle without `req_valid`, the result outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe; the observation bits below are taken in this cycle |
| in_x | input | 1 | Applied operand bit x |
| in_y | input | 1 | Applied operand bit y |
| in_z | input | 1 | Applied carry-in bit z |
| obs_sum | input | 1 | Observed sum output |
| obs_carry | input | 1 | Observed carry output |
| res_valid | output | 1 | Result valid pulse, one cycle after the request |
| suspects | output | 5 | Candidate gates {o1, a2, a1, x2, x1} |
| healthy | output | 1 | Observation matches a fault-free adder |
| sole | output | 1 | Exactly one candidate gate |
| unexplained | output | 1 | Mismatch that no single gate accounts for |

## Verification
The assertions take for granted that the five observation bits are settled and meaningful whenever the request strobe is high, and that a result is judged only in the cycle after its request. The stimulus changes the observation bits only at the falling edge, so each request is captured cleanly. It also drives random bits while the strobe is low, which exercises the hold behaviour. Every one of the 32 observation patterns is applied directly, and random requests are mixed with idle cycles.

// File: rtl/fa_diag_pkg.sv
package fa_diag_pkg;

   localparam int unsigned GATE_COUNT = 5;

   // Gate indices; they set the bit order of the suspect mask.
   localparam int unsigned G_X1 = 0;
   localparam int unsigned G_X2 = 1;
   localparam int unsigned G_A1 = 2;
   localparam int unsigned G_A2 = 3;
   localparam int unsigned G_O1 = 4;

   // Index meaning "no gate overridden".
   localparam int unsigned G_NONE = GATE_COUNT;

   typedef struct packed {
      logic x;
      logic y;
      logic z;
   } fa_operands_t;

   typedef struct packed {
      logic sum;
      logic carry;
   } fa_outputs_t;

endpackage

// File: rtl/fa_diag_model.sv
module fa_diag_model
   import fa_diag_pkg::*;
#(
   parameter int unsigned FORCE_IDX = G_NONE,
   parameter bit          FORCE_VAL = 1'b0
) (
   input  fa_operands_t ops,
   output fa_outputs_t  outs
);

   initial begin
      if (FORCE_IDX > G_NONE)
         $error("fa_diag_model: FORCE_IDX %0d out of range", FORCE_IDX);
   end

   logic n_mid;
   logic n_and_a;
   logic n_and_b;
   logic n_sum;
   logic n_carry;

   // Each gate is either its healthy function or the forced constant.
   generate
      if (FORCE_IDX == G_X1) begin : g_x1_forced
         assign n_mid = FORCE_VAL;
      end else begin : g_x1_ok
         assign n_mid = ops.x ^ ops.y;
      end

      if (FORCE_IDX == G_A1) begin : g_a1_forced
         assign n_and_a = FORCE_VAL;
      end else begin : g_a1_ok
         assign n_and_a = ops.z & n_mid;
      end

      if (FORCE_IDX == G_A2) begin : g_a2_forced
         assign n_and_b = FORCE_VAL;
      end else begin : g_a2_ok
         assign n_and_b = ops.x & ops.y;
      end

      if (FORCE_IDX == G_X2) begin : g_x2_forced
         assign n_sum = FORCE_VAL;
      end else begin : g_x2_ok
         assign n_sum = n_mid ^ ops.z;
      end

      if (FORCE_IDX == G_O1) begin : g_o1_forced
         assign n_carry = FORCE_VAL;
      end else begin : g_o1_ok
         assign n_carry = n_and_a | n_and_b;
      end
   endgenerate

   assign outs.sum   = n_sum;
   assign outs.carry = n_carry;

endmodule

// File: rtl/fa_diag_judge.sv
module fa_diag_judge #(
   parameter int unsigned GATES = 5
) (
   input  logic [GATES-1:0] explains,
   input  logic             mismatch,
   output logic [GATES-1:0] mask,
   output logic             no_fault,
   output logic             one_hit,
   output logic             none_hit
);

   initial begin
      if (GATES < 2)
         $error("fa_diag_judge: GATES must be at least 2");
   end

   logic [$clog2(GATES+1)-1:0] hit_count;

   always_comb begin
      hit_count = '0;
      for (int i = 0; i < GATES; i++)
         hit_count = hit_count + {{($clog2(GATES+1)-1){1'b0}}, mask[i]};
   end

   // A matching observation is explained by every gate at its healthy value,
   // so the mask is cleared in that case.
   assign mask     = mismatch ? explains : '0;
   assign no_fault = ~mismatch;
   assign one_hit  = (hit_count == 1);
   assign none_hit = mismatch & (mask == '0);

   always_comb begin
      a_r7_flags_exclusive: assert ($onehot0({no_fault, one_hit, none_hit}))
         else $error("diagnosis flags overlap");
   end

endmodule

// File: rtl/fa_single_fault_diag.sv
module fa_single_fault_diag
   import fa_diag_pkg::*;
#(
   parameter int unsigned GATES = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             in_x,
   input  logic             in_y,
   input  logic             in_z,
   input  logic             obs_sum,
   input  logic             obs_carry,
   output logic             res_valid,
   output logic [GATES-1:0] suspects,
   output logic             healthy,
   output logic             sole,
   output logic             unexplained
);

   initial begin
      if (GATES != GATE_COUNT)
         $error("fa_single_fault_diag: GATES must equal %0d", GATE_COUNT);
   end

   localparam int unsigned FORCE_CHOICES = 2;

   fa_operands_t ops;
   fa_outputs_t  seen;
   fa_outputs_t  ref_outs;

   assign ops  = '{x: in_x, y: in_y, z: in_z};
   assign seen = '{sum: obs_sum, carry: obs_carry};

   // Healthy prediction.
   fa_diag_model #(.FORCE_IDX(G_NONE), .FORCE_VAL(1'b0)) u_healthy (
      .ops  (ops),
      .outs (ref_outs)
   );

   logic [GATES-1:0][FORCE_CHOICES-1:0] reproduces;
   logic [GATES-1:0]                    explains;

   // One faulted copy of the adder per gate and per stuck value.
   generate
      for (genvar g = 0; g < GATES; g++) begin : g_gate
         for (genvar v = 0; v < FORCE_CHOICES; v++) begin : g_val
            fa_outputs_t faulted;
            fa_diag_model #(.FORCE_IDX(g), .FORCE_VAL(v[0])) u_model (
               .ops  (ops),
               .outs (faulted)
            );
            assign reproduces[g][v] = (faulted == seen);
         end
         assign explains[g] = |reproduces[g];
      end
   endgenerate

   logic             mismatch;
   logic [GATES-1:0] mask_d;
   logic             no_fault_d;
   logic             one_hit_d;
   logic             none_hit_d;

   assign mismatch = (ref_outs != seen);

   fa_diag_judge #(.GATES(GATES)) u_judge (
      .explains (explains),
      .mismatch (mismatch),
      .mask     (mask_d),
      .no_fault (no_fault_d),
      .one_hit  (one_hit_d),
      .none_hit (none_hit_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         suspects    <= '0;
         healthy     <= 1'b0;
         sole        <= 1'b0;
         unexplained <= 1'b0;
      end else begin
         res_valid <= req_valid;
         if (req_valid) begin
            suspects    <= mask_d;
            healthy     <= no_fault_d;
            sole        <= one_hit_d;
            unexplained <= none_hit_d;
         end
      end
   end

   // Assertions on the registered result against the captured request.
   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid);

   a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !res_valid);

   a_r2_match_is_healthy: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && obs_sum == (in_x ^ in_y ^ in_z)
                 && obs_carry == ((in_x & in_y) | (in_z & (in_x | in_y))))
      |=> (healthy && suspects == '0));

   a_r4_sum_suspects: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && obs_sum != (in_x ^ in_y ^ in_z))
      |=> (suspects[G_O1] == 1'b0 && suspects[G_A2] == 1'b0 && suspects[G_A1] == 1'b0));

   a_r5_carry_suspects: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && obs_carry != ((in_x & in_y) | (in_z & (in_x | in_y))))
      |=> !suspects[G_X2]);

   a_r6_sole_count: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (sole == ($countones(suspects) == 1)));

   a_r7_unexplained_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && unexplained) |-> (suspects == '0 && !healthy));

   a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(suspects) && $stable(healthy)
                      && $stable(sole) && $stable(unexplained)));

endmodule

// File: tb/tb_fa_single_fault_diag.sv
module tb_fa_single_fault_diag;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       in_x = 1'b0, in_y = 1'b0, in_z = 1'b0;
   logic       obs_sum = 1'b0, obs_carry = 1'b0;
   logic       res_valid;
   logic [4:0] suspects;
   logic       healthy, sole, unexplained;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   fa_single_fault_diag dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .in_x(in_x), .in_y(in_y), .in_z(in_z),
      .obs_sum(obs_sum), .obs_carry(obs_carry),
      .res_valid(res_valid), .suspects(suspects), .healthy(healthy),
      .sole(sole), .unexplained(unexplained)
   );

   // Adder with gate fi (0 x1,1 x2,2 a1,3 a2,4 o1; 5 none) stuck at fv; returns {sum,carry}.
   function automatic logic [1:0] adder(logic x, logic y, logic z, int fi, logic fv);
      logic o, a, b, s, c;
      o = (fi == 0) ? fv : (x ^ y);
      a = (fi == 2) ? fv : (z & o);
      b = (fi == 3) ? fv : (x & y);
      s = (fi == 1) ? fv : (o ^ z);
      c = (fi == 4) ? fv : (a | b);
      return {s, c};
   endfunction

   // Expected {mask[4:0], healthy, sole, unexplained}.
   function automatic logic [7:0] expect_res(logic x, logic y, logic z, logic s, logic c);
      logic [4:0] m;
      logic       mis;
      int         n;
      mis = (adder(x, y, z, 5, 1'b0) != {s, c});
      m = '0;
      n = 0;
      for (int g = 0; g < 5; g++)
         if (adder(x, y, z, g, 1'b0) == {s, c} || adder(x, y, z, g, 1'b1) == {s, c})
            m[g] = 1'b1;
      if (!mis) m = '0;
      for (int g = 0; g < 5; g++) n += m[g];
      return {m, !mis, n == 1, mis && m == '0};
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   function automatic logic [7:0] result();
      return {suspects, healthy, sole, unexplained};
   endfunction

   // Issue one request and check its result plus the per-rule properties.
   task automatic request(logic [4:0] v);
      logic [7:0] e;
      @(negedge clk);
      {in_x, in_y, in_z, obs_sum, obs_carry} = v;
      req_valid = 1'b1;
      e = expect_res(v[4], v[3], v[2], v[1], v[0]);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R1 valid", {7'd0, res_valid}, 8'd1);
      chk("R3 R6 R7 result", result(), e);
      if (e[2]) chk("R2 healthy", result(), 8'b00000100);
      if (v[1] != (v[4] ^ v[3] ^ v[2])) chk("R4 sum", {5'd0, suspects[4:2]}, 8'd0);
      if (v[0] != ((v[4] & v[3]) | (v[2] & (v[4] | v[3]))))
         chk("R5 carry", {7'd0, suspects[1]}, 8'd0);
   endtask

   initial begin
      logic [7:0] held;
      void'($urandom(32'h5eed_0c1d));
      chk("R1 reset", {result()[7:0] | {7'd0, res_valid}}, 8'd0);
      #20 rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset after release", {7'd0, res_valid} | result(), 8'd0);

      // R8 directed case.
      request(5'b10110);
      chk("R8 x1 culprit", result(), {5'b00001, 3'b010});

      // Every observation pattern.
      for (int p = 0; p < 32; p++) request(p[4:0]);

      // R9: idle cycles with random data do not alter the result.
      request(5'b11010);
      held = result();
      for (int k = 0; k < 4; k++) begin
         {in_x, in_y, in_z, obs_sum, obs_carry} = 5'($urandom);
         @(negedge clk);
         chk("R9 hold", result(), held);
         chk("R1 no valid when idle", {7'd0, res_valid}, 8'd0);
      end

      // Random requests with random idle gaps.
      for (int k = 0; k < 300; k++) begin
         request(5'($urandom));
         if ($urandom % 3 == 0) begin
            held = result();
            {in_x, in_y, in_z, obs_sum, obs_carry} = 5'($urandom);
            @(negedge clk);
            chk("R9 hold random", result(), held);
         end
      end
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule